// File: doc/BRIEF.md
# Flash Command Controller with Write Suspend and Lock Protection

This block is the command decoder and write sequencer for a small byte-wide flash array. Bus write cycles arrive on a valid/ready command channel carrying an opcode, an address and a data byte. Multi-cycle commands such as byte writes and lock-bit setting are run by an internal sequencer. A cycle counter stands in for the real programming time. A running byte write can be paused at a safe point, so that other locations can be read, and then resumed. Per-block lock bits, and a master lock bit that guards them, protect the array. The master lock can be overridden by a high-voltage flag sampled from the reset pin.

Software follows the 8-bit status register through the `status` pin, or through `rd_data` when status read mode is selected. Bit 7 is ready. Bit 5 flags a bad command sequence. Bit 4 flags a failed write or lock operation. Bit 3 flags a missing program voltage. Bit 2 flags a suspended write. Bit 1 flags a lock violation. Bits 6 and 0 always read 0.

Command channel rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` never depends on `cmd_valid`. A source whose command is not accepted keeps opcode, address and data stable until it is. `cmd_ready` is low while a lock bit is being programmed and during the two-cycle suspend latency. Everywhere else it is high, and a command that is not legal in the current state is consumed without effect.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `status` reads 0x80, read mode is array, all lock bits are clear and every array byte reads 0.
- R2: A byte write is opcode 0x40 followed by a data cycle (any opcode, carrying address and data). It holds status bit 7 at 0 for exactly PROG_CYCLES cycles after the data cycle, then stores the byte. Reads return the status register until a new read command is issued.
- R3: Opcode 0xFF selects array read mode, where `rd_data` shows the byte at `rd_addr`. Opcode 0x70 selects status read mode, where `rd_data` shows the status register.
- R4: Opcode 0xB0 during a running byte write freezes the write timer. Two cycles after acceptance, status bits 7 and 2 both read 1. Opcode 0xB0 with no write running changes nothing.
- R5: While a write is suspended only 0xFF, 0x70 and 0xD0 act. Any other opcode leaves the status and the array unchanged. The target byte still reads its old value.
- R6: Opcode 0xD0 while suspended clears status bits 2 and 7 on the next cycle. The write then finishes after the cycles it had left.
- R7: Opcode 0x60 followed by confirm 0x01 with an address in block b (block = upper address bits) sets that block's lock bit after LOCK_CYCLES busy cycles. A byte write into a locked block sets status bits 1 and 4 and leaves the array unchanged.
- R8: A lock setup 0x60 followed by any opcode other than 0x01 or 0xF1 sets status bits 5 and 4 and changes no lock bit.
- R9: Setup 0x60 then master confirm 0xF1 sets the master lock only when `rp_hv` is high at the confirm. Otherwise status bits 1 and 4 are set and the master lock is unchanged.
- R10: With the master lock set, a block lock succeeds only if `rp_hv` is high at the confirm. Otherwise status bits 1 and 4 are set.
- R11: If `vpp_ok` is low at a byte write data cycle or a lock confirm, status bits 3 and 4 are set and nothing is programmed.
- R12: Status bits 1, 3, 4 and 5 stay set until opcode 0x50 in idle clears them, and the clear removes all four.
- R13: `cmd_ready` is low for all LOCK_CYCLES cycles of lock programming and during the suspend latency. It is high while a byte write is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command cycle present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 8 | Opcode of the bus write cycle |
| cmd_addr | input | AW (5) | Byte address; upper bits pick the block |
| cmd_data | input | DW (8) | Data byte for the byte write data cycle |
| rp_hv | input | 1 | High-voltage level present on the reset pin |
| vpp_ok | input | 1 | Program voltage valid |
| rd_addr | input | AW (5) | Array read address |
| rd_data | output | DW (8) | Array byte or status register, by read mode |
| status | output | 8 | Status register, always visible |

## Verification
Byte writes are tried with random addresses and data, mixed with random block locks and occasional dropped program voltage. This shows that the lock gate and the voltage check block the right writes and no others. A directed suspend in the middle of a write, with an illegal opcode issued while suspended, tells a frozen timer apart from a running one, and a true pause apart from a silent completion. Lock sequences are run with and without the high-voltage flag, both before and after the master lock is set. Malformed confirms are also applied. These cases tell the master gate, the sequence check and the sticky status clear apart.

// File: rtl/flcc_pkg.sv
package flcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_DATA,
    ST_LK_CONF,
    ST_BUSY_WR,
    ST_SUSP_PEND,
    ST_SUSPENDED,
    ST_BUSY_LK
  } cui_state_e;

  typedef struct packed {
    logic seq_err;
    logic prog_err;
    logic vpp_err;
    logic lock_err;
  } err_flags_t;
endpackage

// File: rtl/flcc_array.sv
module flcc_array #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flcc_lock_bank.sv
module flcc_lock_bank #(
  parameter int NBLK = 4,
  parameter int BW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            set_master,
  input  logic [BW-1:0]   set_blk,
  output logic [NBLK-1:0] blk_locks,
  output logic            master_lock
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n) blk_locks[b] <= 1'b0;
      else if (set_en && !set_master && set_blk == BW'(b)) blk_locks[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) master_lock <= 1'b0;
    else if (set_en && set_master) master_lock <= 1'b1;
  end

  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_locks != '0) |=> ((blk_locks & $past(blk_locks)) == $past(blk_locks))); // R7
endmodule

// File: rtl/flcc_wsm_timer.sv
module flcc_wsm_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == CW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0)); // R2
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flcc_pkg::*;
#(
  parameter int NBLK        = 4,
  parameter int BLK_WORDS   = 8,
  parameter int DW          = 8,
  parameter int AW          = $clog2(NBLK) + $clog2(BLK_WORDS),
  parameter int PROG_CYCLES = 6,
  parameter int LOCK_CYCLES = 4,
  parameter logic [7:0] OP_RD_ARRAY  = 8'hFF,
  parameter logic [7:0] OP_RD_STATUS = 8'h70,
  parameter logic [7:0] OP_CLR_STAT  = 8'h50,
  parameter logic [7:0] OP_WR_SETUP  = 8'h40,
  parameter logic [7:0] OP_SUSPEND   = 8'hB0,
  parameter logic [7:0] OP_RESUME    = 8'hD0,
  parameter logic [7:0] OP_LK_SETUP  = 8'h60,
  parameter logic [7:0] OP_LK_BLOCK  = 8'h01,
  parameter logic [7:0] OP_LK_MASTER = 8'hF1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          rp_hv,
  input  logic          vpp_ok,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status
);
  localparam int BW    = $clog2(NBLK);
  localparam int MAXC  = (PROG_CYCLES > LOCK_CYCLES) ? PROG_CYCLES : LOCK_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);

  cui_state_e    st;
  err_flags_t    err;
  logic          stat_mode;
  logic [1:0]    sp_cnt;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;
  logic [BW-1:0] lk_blk;
  logic          lk_master;

  logic            acc;
  logic [BW-1:0]   q_blk;
  logic [NBLK-1:0] blk_locks;
  logic            master_lock;
  logic            q_locked;
  logic            is_conf;
  logic            lk_perm;
  logic            start_wr;
  logic            start_lk;
  logic            t_run;
  logic            t_done;
  logic [CW-1:0]   t_val;
  logic            arr_we;
  logic            lk_set;
  logic [DW-1:0]   arr_rdata;
  logic            sr_ready;
  logic            sr_susp;

  // command channel and decode helpers
  assign cmd_ready = !(st == ST_SUSP_PEND || st == ST_BUSY_LK);
  assign acc       = cmd_valid && cmd_ready;
  assign q_blk     = cmd_addr[AW-1 -: BW];
  assign q_locked  = blk_locks[q_blk];
  assign is_conf   = (cmd_op == OP_LK_BLOCK) || (cmd_op == OP_LK_MASTER);
  assign lk_perm   = (cmd_op == OP_LK_MASTER) ? rp_hv : (!master_lock || rp_hv);
  assign start_wr  = (st == ST_WR_DATA) && acc && vpp_ok && !q_locked;
  assign start_lk  = (st == ST_LK_CONF) && acc && is_conf && vpp_ok && lk_perm;

  // sequencer timing
  assign t_run  = (st == ST_BUSY_WR) || (st == ST_BUSY_LK);
  assign t_val  = start_wr ? CW'(PROG_CYCLES) : CW'(LOCK_CYCLES);
  assign arr_we = (st == ST_BUSY_WR) && t_done;
  assign lk_set = (st == ST_BUSY_LK) && t_done;

  flcc_wsm_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_wr || start_lk),
    .load_val (t_val),
    .run      (t_run),
    .done     (t_done)
  );

  flcc_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .waddr (wa),
    .wdata (wd),
    .raddr (rd_addr),
    .rdata (arr_rdata)
  );

  flcc_lock_bank #(.NBLK(NBLK), .BW(BW)) u_locks (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (lk_set),
    .set_master  (lk_master),
    .set_blk     (lk_blk),
    .blk_locks   (blk_locks),
    .master_lock (master_lock)
  );

  // command user interface state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      err       <= '0;
      stat_mode <= 1'b0;
      sp_cnt    <= '0;
      wa        <= '0;
      wd        <= '0;
      lk_blk    <= '0;
      lk_master <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          if (cmd_op == OP_RD_ARRAY) stat_mode <= 1'b0;
          else if (cmd_op == OP_RD_STATUS) stat_mode <= 1'b1;
          else if (cmd_op == OP_CLR_STAT) err <= '0;
          else if (cmd_op == OP_WR_SETUP) begin
            st        <= ST_WR_DATA;
            stat_mode <= 1'b1;
          end else if (cmd_op == OP_LK_SETUP) begin
            st        <= ST_LK_CONF;
            stat_mode <= 1'b1;
          end
        end
        ST_WR_DATA: if (acc) begin
          if (!vpp_ok) begin
            err.vpp_err  <= 1'b1;
            err.prog_err <= 1'b1;
            st           <= ST_IDLE;
          end else if (q_locked) begin
            err.lock_err <= 1'b1;
            err.prog_err <= 1'b1;
            st           <= ST_IDLE;
          end else begin
            wa <= cmd_addr;
            wd <= cmd_data;
            st <= ST_BUSY_WR;
          end
        end
        ST_LK_CONF: if (acc) begin
          if (!is_conf) begin
            err.seq_err  <= 1'b1;
            err.prog_err <= 1'b1;
            st           <= ST_IDLE;
          end else if (!vpp_ok) begin
            err.vpp_err  <= 1'b1;
            err.prog_err <= 1'b1;
            st           <= ST_IDLE;
          end else if (!lk_perm) begin
            err.lock_err <= 1'b1;
            err.prog_err <= 1'b1;
            st           <= ST_IDLE;
          end else begin
            lk_master <= (cmd_op == OP_LK_MASTER);
            lk_blk    <= q_blk;
            st        <= ST_BUSY_LK;
          end
        end
        ST_BUSY_WR: begin
          if (t_done) st <= ST_IDLE;
          else if (acc && cmd_op == OP_SUSPEND) begin
            st     <= ST_SUSP_PEND;
            sp_cnt <= 2'd1;
          end else if (acc && cmd_op == OP_RD_STATUS) stat_mode <= 1'b1;
        end
        ST_SUSP_PEND: begin
          if (sp_cnt == '0) st <= ST_SUSPENDED;
          else sp_cnt <= sp_cnt - 1'b1;
        end
        ST_SUSPENDED: if (acc) begin
          if (cmd_op == OP_RD_ARRAY) stat_mode <= 1'b0;
          else if (cmd_op == OP_RD_STATUS) stat_mode <= 1'b1;
          else if (cmd_op == OP_RESUME) begin
            st        <= ST_BUSY_WR;
            stat_mode <= 1'b1;
          end
        end
        ST_BUSY_LK: if (t_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // status register and read mux
  assign sr_ready = !(st == ST_BUSY_WR || st == ST_SUSP_PEND || st == ST_BUSY_LK);
  assign sr_susp  = (st == ST_SUSPENDED);
  assign status   = {sr_ready, 1'b0, err.seq_err, err.prog_err, err.vpp_err,
                     sr_susp, err.lock_err, 1'b0};
  assign rd_data  = stat_mode ? DW'(status) : arr_rdata;

  AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[7]); // R4
  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSPENDED && acc && cmd_op == OP_RESUME) |=> (!status[2] && !status[7])); // R6
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !blk_locks[wa[AW-1 -: BW]]); // R7
  AST_BAD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LK_CONF && acc && !is_conf) |=> (status[5] && status[4])); // R8
  AST_MASTER_HV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LK_CONF && acc && cmd_op == OP_LK_MASTER && vpp_ok && !rp_hv)
      |=> (status[1] && status[4] && status[7])); // R9
  AST_STICKY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(st == ST_IDLE && acc && cmd_op == OP_CLR_STAT)) |=> status[4]); // R12
  AST_SUSP_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY_WR && !t_done && acc && cmd_op == OP_SUSPEND) |=> !cmd_ready); // R13
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int PROG = 6;
  localparam int LOCKC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic rp_hv = 1'b0;
  logic vpp_ok = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] m_mem [32];
  logic [3:0] m_lock;
  logic m_master;
  logic e_seq, e_prog, e_vpp, e_lock;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rp_hv(rp_hv),
    .vpp_ok(vpp_ok), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [7:0] exp_status();
    return {1'b1, 1'b0, e_seq, e_prog, e_vpp, 1'b0, e_lock, 1'b0};
  endfunction

  function automatic int blk_of(logic [AW-1:0] a);
    return int'(a[AW-1 -: 2]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] op, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int low, output int rlow);
    low = 0; rlow = 0;
    @(negedge clk);
    while (!status[7] && low < 1000) begin
      low++;
      if (!cmd_ready) rlow++;
      @(negedge clk);
    end
  endtask

  task automatic clear_status();
    send(8'h50, '0, '0);
    e_seq = 0; e_prog = 0; e_vpp = 0; e_lock = 0;
    @(negedge clk);
    chk("R12", status, exp_status());
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a);
    send(8'hFF, '0, '0);
    rd_addr = a;
    #1 chk(req, rd_data, m_mem[a]);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [7:0] d, logic vp);
    int low, rlow;
    bit go;
    send(8'h40, '0, '0);
    vpp_ok = vp;
    send(8'h00, a, d);
    vpp_ok = 1'b1;
    go = 0;
    if (!vp) begin e_vpp = 1; e_prog = 1; end
    else if (m_lock[blk_of(a)]) begin e_lock = 1; e_prog = 1; end
    else begin go = 1; m_mem[a] = d; end
    wait_idle(low, rlow);
    chk(go ? "R2 busy" : (vp ? "R7 no busy" : "R11 no busy"), low, go ? PROG : 0);
    chk("R13 ready in write", rlow, 0);
    chk(go ? "R2 status" : (vp ? "R7 status" : "R11 status"), status, exp_status());
    chk("R2 reads status", rd_data, exp_status());
  endtask

  task automatic do_lock(logic [7:0] conf, logic [AW-1:0] a, logic hv, logic vp);
    int low, rlow;
    bit go;
    send(8'h60, '0, '0);
    rp_hv = hv; vpp_ok = vp;
    send(conf, a, '0);
    rp_hv = 1'b0; vpp_ok = 1'b1;
    go = 0;
    if (conf != 8'h01 && conf != 8'hF1) begin e_seq = 1; e_prog = 1; end
    else if (!vp) begin e_vpp = 1; e_prog = 1; end
    else if (conf == 8'hF1 && !hv) begin e_lock = 1; e_prog = 1; end
    else if (conf == 8'h01 && m_master && !hv) begin e_lock = 1; e_prog = 1; end
    else begin
      go = 1;
      if (conf == 8'hF1) m_master = 1; else m_lock[blk_of(a)] = 1;
    end
    wait_idle(low, rlow);
    chk(go ? "R7 lock busy" : "R8 R9 R10 no busy", low, go ? LOCKC : 0);
    chk("R13 ready low in lock", rlow, go ? LOCKC : 0);
    chk(conf == 8'hF1 ? "R9 status" : (m_master ? "R10 status" : "R8 R7 status"),
        status, exp_status());
  endtask

  initial begin
    int low, rlow;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_lock = '0; m_master = 0;
    e_seq = 0; e_prog = 0; e_vpp = 0; e_lock = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    chk("R1 status", status, 8'h80);
    rd_addr = 5'd3;
    #1 chk("R1 array zero", rd_data, 8'h00);
    chk("R1 ready", cmd_ready, 1);

    do_write(5'd5, 8'h5A, 1);
    rd_chk("R3 array read", 5'd5);
    send(8'h70, '0, '0);
    #1 chk("R3 status mode", rd_data, 8'h80);

    // suspend with nothing running
    send(8'hB0, '0, '0);
    @(negedge clk);
    chk("R4 idle suspend ignored", status, 8'h80);
    chk("R4 idle suspend ready", cmd_ready, 1);

    // suspend / resume flow
    send(8'h40, '0, '0);
    send(8'h00, 5'd20, 8'hC3);
    send(8'hB0, '0, '0);
    @(negedge clk);
    chk("R13 latency ready low", cmd_ready, 0);
    chk("R4 pending busy", status, 8'h00);
    @(negedge clk);
    chk("R4 still pending", status, 8'h00);
    @(negedge clk);
    chk("R4 suspended flags", status, 8'h84);
    repeat (5) @(negedge clk);
    chk("R4 frozen", status, 8'h84);
    send(8'h40, '0, '0);
    send(8'h60, '0, '0);
    @(negedge clk);
    chk("R5 illegal ignored", status, 8'h84);
    rd_chk("R5 old byte", 5'd20);
    send(8'h70, '0, '0);
    #1 chk("R3 R5 status read", rd_data, 8'h84);
    send(8'hD0, '0, '0);
    m_mem[20] = 8'hC3;
    wait_idle(low, rlow);
    chk("R6 remaining cycles", low, PROG - 1);
    chk("R6 done status", status, 8'h80);
    rd_chk("R6 byte stored", 5'd20);

    // block lock and write protection
    do_lock(8'h01, 5'd9, 0, 1);
    do_write(5'd10, 8'h77, 1);
    chk("R7 lock flags", status, 8'h92);
    rd_chk("R7 array unchanged", 5'd10);
    clear_status();
    do_write(5'd17, 8'h3C, 1);
    rd_chk("R7 other block", 5'd17);

    // invalid sequence, stickiness
    do_lock(8'h22, 5'd0, 0, 1);
    chk("R8 seq flags", status, 8'hB0);
    do_write(5'd1, 8'h11, 1);
    chk("R12 sticky", status, 8'hB0);
    clear_status();

    // program voltage missing
    do_write(5'd2, 8'h99, 0);
    chk("R11 vpp flags", status, 8'h98);
    rd_chk("R11 unchanged", 5'd2);
    do_lock(8'h01, 5'd26, 0, 0);
    chk("R11 lock vpp", status, 8'h98);
    clear_status();

    // random mix
    for (int n = 0; n < 40; n++) begin
      int r;
      logic [AW-1:0] a;
      r = int'($urandom % 10);
      a = AW'($urandom);
      if (r == 0) do_lock(8'h01, a, 0, 1);
      else do_write(a, 8'($urandom), ($urandom % 8) != 0);
      if (e_prog) clear_status();
      if (r > 6) rd_chk("R2 random readback", a);
    end

    // master lock
    do_lock(8'hF1, 5'd0, 0, 1);
    chk("R9 master refused", status, 8'h92);
    clear_status();
    do_lock(8'h01, 5'd30, 0, 1);
    chk("R9 master unchanged", status, 8'h80);
    do_lock(8'hF1, 5'd0, 1, 1);
    chk("R9 master set", status, 8'h80);
    if (!m_lock[0]) begin
      do_lock(8'h01, 5'd2, 0, 1);
      chk("R10 needs hv", status, 8'h92);
      clear_status();
    end
    do_lock(8'h01, 5'd2, 1, 1);
    chk("R10 hv ok", status, 8'h80);
    do_write(5'd3, 8'h44, 1);
    chk("R7 block0 locked", status, 8'h92);
    clear_status();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule